// File: doc/BRIEF.md
# Two-Way Flash Read Cache

This block sits between a processor's fetch and load port and a slow flash array, and serves reads only. Storage is organised as 256 sets of two ways, each way holding one 16-byte line, for 512 lines in total. A lookup that hits answers from the line store. A miss reads the whole line from flash, writes it into one way of its set and returns the requested 32-bit word in the same cycle as the fill.

Run-time inputs control the cache. A master enable and two class enables, one for instruction fetches and one for data loads, decide which requests may allocate. One bit selects victim choice by least-recently-replaced or least-recently-used order. Two address windows, each with its own enable and inclusive line-granular bounds, force requests to go straight to flash. A wait-state count sets when the flash data is sampled. An invalidate pulse clears every line, one set per clock, and a ready flag reports a usable cache.

Top module: `flash_rd_cache`

## Requirements
- R1: After reset `rsp_valid` and `fl_rd` are low, `req_ready` is high, and every line is invalid.
- R2: `req_waddr` is a 32-bit word address. Its bits [1:0] choose the word in the line, with word 0 in line bits [31:0]. Bits [9:2] choose the set and bits [21:10] form the tag. `fl_addr` carries the line address, `req_waddr[21:2]`.
- R3: A cacheable request that hits raises `rsp_valid` for one cycle, one clock edge after the edge that accepted it, with no flash read.
- R4: A cacheable miss pulses `fl_rd` for one cycle, fills one way with `fl_rdata` and returns the selected word in the same cycle. `rsp_valid` rises `cfg_wait + 2` edges after acceptance.
- R5: `fl_rdata` is sampled exactly `cfg_wait` (0 to 3) cycles after the cycle in which `fl_rd` is high.
- R6: With `cfg_en` low, or with the enable for the request's class low (`req_instr` = 1 is a fetch gated by `cfg_ien`, 0 is a load gated by `cfg_den`), every request reads flash and allocates nothing.
- R7: Window w uses enable `cfg_win_en[w]` and bounds `cfg_win_lo/hi[w*20 +: 20]`, compared against the line address. A request with lo <= line address <= hi in an enabled window reads flash and allocates nothing.
- R8: The victim is an invalid way if there is one, way 0 first. Otherwise it is the way given by per-set replacement state. With `cfg_lru` = 0 that state changes only on fills, so the least recently filled way is evicted.
- R9: With `cfg_lru` = 1, hits also update replacement state, so the least recently used way is evicted.
- R10: An `inv_req` pulse clears every valid bit in a sweep of 256 cycles. During the sweep no request is accepted. `ready` is high only when `cfg_en` is set and no invalidate is running or pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Master caching enable |
| cfg_ien | input | 1 | Allow caching of instruction fetches |
| cfg_den | input | 1 | Allow caching of data loads |
| cfg_lru | input | 1 | Victim policy: 0 least recently replaced, 1 least recently used |
| cfg_wait | input | 2 | Flash read wait states |
| cfg_win_en | input | 2 | Per-window bypass enable |
| cfg_win_lo | input | 40 | Lower line-address bound of each window |
| cfg_win_hi | input | 40 | Upper line-address bound of each window |
| inv_req | input | 1 | Start a whole-cache invalidate |
| ready | output | 1 | Cache enabled and not invalidating |
| req_valid | input | 1 | Read request present |
| req_instr | input | 1 | Request is an instruction fetch |
| req_waddr | input | 22 | Word address of the request |
| req_ready | output | 1 | Request accepted on this edge when valid |
| rsp_valid | output | 1 | Read data present for one cycle |
| rsp_data | output | 32 | Read data |
| fl_rd | output | 1 | One-cycle flash line read strobe |
| fl_addr | output | 20 | Line address of the flash read, held until the response |
| fl_rdata | input | 128 | Line returned by flash |

## Verification
The bench builds the block with its default parameters: 24-bit byte addressing, 256 sets, 128-bit lines and two bypass windows. Because of this the full 256-cycle invalidate sweep is timed end to end, and set and tag bits are placed exactly as the requirements state. The bench's flash model drives valid data in only one cycle, chosen by its own wait count, so a sampling point off by one cycle for any `cfg_wait` from 0 to 3 returns zeros. Victim choice is told apart by how many flash reads follow a three-tag conflict in one set.

// File: rtl/frc_pkg.sv
package frc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOOK = 2'd1,
      ST_WAIT = 2'd2,
      ST_INV  = 2'd3
   } frc_state_e;
endpackage

// File: rtl/frc_window.sv
module frc_window #(
   parameter int NWIN = 2,
   parameter int LA_W = 20
) (
   input  logic [LA_W-1:0]      line_addr,
   input  logic [NWIN-1:0]      win_en,
   input  logic [NWIN*LA_W-1:0] win_lo,
   input  logic [NWIN*LA_W-1:0] win_hi,
   output logic                 in_window
);
   logic [NWIN-1:0] w_hit;

   generate
      for (genvar w = 0; w < NWIN; w++) begin : g_win
         assign w_hit[w] = win_en[w]
                        && (line_addr >= win_lo[w*LA_W +: LA_W])
                        && (line_addr <= win_hi[w*LA_W +: LA_W]);
      end
   endgenerate

   assign in_window = |w_hit;
endmodule

// File: rtl/frc_line_store.sv
module frc_line_store #(
   parameter int SETS   = 256,
   parameter int TAG_W  = 12,
   parameter int LINE_W = 128,
   localparam int IDX_W = $clog2(SETS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [IDX_W-1:0]    idx,
   input  logic [TAG_W-1:0]    tag,
   input  logic                fill_en,
   input  logic                fill_way,
   input  logic [LINE_W-1:0]   fill_line,
   input  logic                clr_en,
   input  logic [IDX_W-1:0]    clr_idx,
   output logic [1:0]          hit_vec,
   output logic [1:0]          way_vld,
   output logic [2*LINE_W-1:0] rd_lines
);
   generate
      for (genvar w = 0; w < 2; w++) begin : g_way
         logic [TAG_W-1:0]  tag_m [SETS];
         logic [LINE_W-1:0] dat_m [SETS];
         logic [SETS-1:0]   vld_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q <= '0;
            end else if (clr_en) begin
               vld_q[clr_idx] <= 1'b0;
            end else if (fill_en && (fill_way == 1'(w))) begin
               vld_q[idx] <= 1'b1;
            end
         end

         always_ff @(posedge clk) begin
            if (fill_en && (fill_way == 1'(w))) begin
               tag_m[idx] <= tag;
               dat_m[idx] <= fill_line;
            end
         end

         assign way_vld[w]                   = vld_q[idx];
         assign hit_vec[w]                   = vld_q[idx] && (tag_m[idx] == tag);
         assign rd_lines[w*LINE_W +: LINE_W] = dat_m[idx];
      end
   endgenerate

   // R8: a fill only follows a miss, so a tag never lives in both ways
   a_r8_single_way_hit: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));
endmodule

// File: rtl/frc_repl.sv
module frc_repl #(
   parameter int SETS = 256,
   localparam int IDX_W = $clog2(SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lru_mode,
   input  logic [IDX_W-1:0] idx,
   input  logic [1:0]       way_vld,
   input  logic             fill_en,
   input  logic             fill_way,
   input  logic             hit_en,
   input  logic             hit_way,
   input  logic             clr_en,
   input  logic [IDX_W-1:0] clr_idx,
   output logic             victim
);
   logic [SETS-1:0] rep_q;

   always_comb begin
      if (!way_vld[0])      victim = 1'b0;
      else if (!way_vld[1]) victim = 1'b1;
      else                  victim = rep_q[idx];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rep_q <= '0;
      end else if (clr_en) begin
         rep_q[clr_idx] <= 1'b0;
      end else if (fill_en) begin
         rep_q[idx] <= ~fill_way;
      end else if (hit_en && lru_mode) begin
         rep_q[idx] <= ~hit_way;
      end
   end

   // R8: in replaced-order mode a hit leaves the replacement state alone
   a_r8_lrr_hit_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (!lru_mode && hit_en && !fill_en && !clr_en) |=> $stable(rep_q));
   // R9: in used-order mode a hit points the set at the other way
   a_r9_lru_hit_moves: assert property (@(posedge clk) disable iff (!rst_n)
      (lru_mode && hit_en && !fill_en && !clr_en) |=> (rep_q[$past(idx)] == ~$past(hit_way)));
endmodule

// File: rtl/flash_rd_cache.sv
module flash_rd_cache
   import frc_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int SETS   = 256,
   parameter int WAYS   = 2,
   parameter int LINE_W = 128,
   parameter int WORD_W = 32,
   parameter int NWIN   = 2,
   parameter int WAIT_W = 2,
   localparam int OFF_W  = $clog2(LINE_W/8),
   localparam int BYTE_W = $clog2(WORD_W/8),
   localparam int LA_W   = ADDR_W - OFF_W,
   localparam int WA_W   = ADDR_W - BYTE_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_en,
   input  logic                 cfg_ien,
   input  logic                 cfg_den,
   input  logic                 cfg_lru,
   input  logic [WAIT_W-1:0]    cfg_wait,
   input  logic [NWIN-1:0]      cfg_win_en,
   input  logic [NWIN*LA_W-1:0] cfg_win_lo,
   input  logic [NWIN*LA_W-1:0] cfg_win_hi,
   input  logic                 inv_req,
   output logic                 ready,
   input  logic                 req_valid,
   input  logic                 req_instr,
   input  logic [WA_W-1:0]      req_waddr,
   output logic                 req_ready,
   output logic                 rsp_valid,
   output logic [WORD_W-1:0]    rsp_data,
   output logic                 fl_rd,
   output logic [LA_W-1:0]      fl_addr,
   input  logic [LINE_W-1:0]    fl_rdata
);
   localparam int IDX_W  = $clog2(SETS);
   localparam int TAG_W  = LA_W - IDX_W;
   localparam int WSEL_W = OFF_W - BYTE_W;

   generate
      if (WAYS != 2)                 $error("flash_rd_cache: only two ways are built");
      if (SETS != (1 << IDX_W))      $error("flash_rd_cache: SETS must be a power of two");
      if (LINE_W % WORD_W != 0)      $error("flash_rd_cache: line must hold whole words");
      if (WSEL_W < 1)                $error("flash_rd_cache: line must hold two or more words");
      if (TAG_W < 1)                 $error("flash_rd_cache: address too narrow for the set count");
   endgenerate

   frc_state_e          st_q;
   logic [LA_W-1:0]     la_q;
   logic [WSEL_W-1:0]   wsel_q;
   logic                cls_q;
   logic                cach_q;
   logic                vict_q;
   logic [WAIT_W-1:0]   cnt_q;
   logic [IDX_W-1:0]    inv_idx_q;
   logic                inv_pend_q;
   logic                rsp_v_q;
   logic [WORD_W-1:0]   rsp_d_q;
   logic                fl_rd_q;

   logic [IDX_W-1:0]    idx;
   logic [TAG_W-1:0]    tag;
   logic                win_hit;
   logic                cach;
   logic [1:0]          hit_vec;
   logic [1:0]          way_vld;
   logic [2*LINE_W-1:0] rd_lines;
   logic                any_hit;
   logic [LINE_W-1:0]   hit_line;
   logic [WORD_W-1:0]   hit_word;
   logic [WORD_W-1:0]   fl_word;
   logic                victim;
   logic                fill_en;
   logic                hit_upd;
   logic                clr_en;

   assign idx = la_q[IDX_W-1:0];
   assign tag = la_q[LA_W-1:IDX_W];

   frc_window #(.NWIN(NWIN), .LA_W(LA_W)) u_window (
      .line_addr (la_q),
      .win_en    (cfg_win_en),
      .win_lo    (cfg_win_lo),
      .win_hi    (cfg_win_hi),
      .in_window (win_hit)
   );

   assign cach = cfg_en && (cls_q ? cfg_ien : cfg_den) && !win_hit;

   frc_line_store #(.SETS(SETS), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .idx       (idx),
      .tag       (tag),
      .fill_en   (fill_en),
      .fill_way  (vict_q),
      .fill_line (fl_rdata),
      .clr_en    (clr_en),
      .clr_idx   (inv_idx_q),
      .hit_vec   (hit_vec),
      .way_vld   (way_vld),
      .rd_lines  (rd_lines)
   );

   frc_repl #(.SETS(SETS)) u_repl (
      .clk      (clk),
      .rst_n    (rst_n),
      .lru_mode (cfg_lru),
      .idx      (idx),
      .way_vld  (way_vld),
      .fill_en  (fill_en),
      .fill_way (vict_q),
      .hit_en   (hit_upd),
      .hit_way  (hit_vec[1]),
      .clr_en   (clr_en),
      .clr_idx  (inv_idx_q),
      .victim   (victim)
   );

   assign any_hit  = |hit_vec;
   assign hit_line = hit_vec[1] ? rd_lines[LINE_W +: LINE_W] : rd_lines[0 +: LINE_W];
   assign hit_word = hit_line[wsel_q*WORD_W +: WORD_W];
   assign fl_word  = fl_rdata[wsel_q*WORD_W +: WORD_W];

   assign fill_en = (st_q == ST_WAIT) && (cnt_q == '0) && cach_q;
   assign hit_upd = (st_q == ST_LOOK) && cach && any_hit;
   assign clr_en  = (st_q == ST_INV);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         la_q       <= '0;
         wsel_q     <= '0;
         cls_q      <= 1'b0;
         cach_q     <= 1'b0;
         vict_q     <= 1'b0;
         cnt_q      <= '0;
         inv_idx_q  <= '0;
         inv_pend_q <= 1'b0;
         rsp_v_q    <= 1'b0;
         rsp_d_q    <= '0;
         fl_rd_q    <= 1'b0;
      end else begin
         rsp_v_q <= 1'b0;
         fl_rd_q <= 1'b0;
         if (inv_req && (st_q != ST_IDLE)) inv_pend_q <= 1'b1;
         case (st_q)
            ST_IDLE: begin
               if (inv_req || inv_pend_q) begin
                  st_q       <= ST_INV;
                  inv_idx_q  <= '0;
                  inv_pend_q <= 1'b0;
               end else if (req_valid) begin
                  la_q   <= req_waddr[WA_W-1:WSEL_W];
                  wsel_q <= req_waddr[WSEL_W-1:0];
                  cls_q  <= req_instr;
                  st_q   <= ST_LOOK;
               end
            end
            ST_LOOK: begin
               cach_q <= cach;
               if (cach && any_hit) begin
                  rsp_v_q <= 1'b1;
                  rsp_d_q <= hit_word;
                  st_q    <= ST_IDLE;
               end else begin
                  fl_rd_q <= 1'b1;
                  cnt_q   <= cfg_wait;
                  vict_q  <= victim;
                  st_q    <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (cnt_q == '0) begin
                  rsp_v_q <= 1'b1;
                  rsp_d_q <= fl_word;
                  st_q    <= ST_IDLE;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: begin
               inv_idx_q <= inv_idx_q + 1'b1;
               if (inv_idx_q == IDX_W'(SETS-1)) st_q <= ST_IDLE;
            end
         endcase
      end
   end

   assign req_ready = (st_q == ST_IDLE) && !inv_req && !inv_pend_q;
   assign ready     = cfg_en && (st_q != ST_INV) && !inv_pend_q;
   assign rsp_valid = rsp_v_q;
   assign rsp_data  = rsp_d_q;
   assign fl_rd     = fl_rd_q;
   assign fl_addr   = la_q;

   // R4: the flash strobe lasts a single cycle
   a_r4_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      fl_rd |=> !fl_rd);
   // R3: each response lasts a single cycle
   a_r3_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
   // R5: no response while wait states remain
   a_r5_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_WAIT && cnt_q != '0) |=> !rsp_valid);
   // R7: a request inside an enabled window always goes to flash
   a_r7_window_to_flash: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_LOOK && win_hit) |=> fl_rd);
   // R10: no acceptance during a sweep, and a sweep runs to its last set
   a_r10_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_INV) |-> !req_ready);
   a_r10_sweep_runs: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_INV && inv_idx_q != IDX_W'(SETS-1)) |=> (st_q == ST_INV));
endmodule

// File: tb/tb_flash_rd_cache.sv
`timescale 1ns/1ps
module tb_flash_rd_cache;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cfg_en = 1'b0, cfg_ien = 1'b0, cfg_den = 1'b0, cfg_lru = 1'b0;
   logic [1:0]   cfg_wait = 2'd0;
   logic [1:0]   cfg_win_en = 2'b00;
   logic [39:0]  cfg_win_lo = '0, cfg_win_hi = '0;
   logic         inv_req = 1'b0;
   logic         ready;
   logic         req_valid = 1'b0, req_instr = 1'b0;
   logic [21:0]  req_waddr = '0;
   logic         req_ready, rsp_valid, fl_rd;
   logic [31:0]  rsp_data;
   logic [19:0]  fl_addr;
   logic [127:0] fl_rdata;

   int checks = 0;
   int errors = 0;
   int fl_count = 0;
   int since = 8;
   int bw = 0;
   logic [127:0] line_img;

   always #2.5 clk = ~clk;

   flash_rd_cache dut (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_ien(cfg_ien), .cfg_den(cfg_den),
      .cfg_lru(cfg_lru), .cfg_wait(cfg_wait), .cfg_win_en(cfg_win_en),
      .cfg_win_lo(cfg_win_lo), .cfg_win_hi(cfg_win_hi), .inv_req(inv_req), .ready(ready),
      .req_valid(req_valid), .req_instr(req_instr), .req_waddr(req_waddr),
      .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .fl_rd(fl_rd), .fl_addr(fl_addr), .fl_rdata(fl_rdata)
   );

   // flash model: data present only in the one cycle set by its own wait count
   always_comb begin
      for (int k = 0; k < 4; k++) line_img[k*32 +: 32] = {4'hC, fl_addr, 6'd0, 2'(k)};
   end
   assign fl_rdata = ((fl_rd && bw == 0) || (!fl_rd && since == bw)) ? line_img : '0;
   always @(posedge clk) begin
      if (fl_rd) begin
         fl_count <= fl_count + 1;
         since    <= 1;
      end else if (since < 8) begin
         since <= since + 1;
      end
   end

   function automatic logic [31:0] exp_word(input logic [23:0] a);
      return {4'hC, a[23:4], 6'd0, a[3:2]};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [23:0] a, input logic ins,
                     output logic [31:0] d, output int nfl, output int lat);
      int base;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1;
      req_addr_set(a);
      req_instr = ins;
      base = fl_count;
      @(posedge clk);
      #1 req_valid = 1'b0;
      lat = 0;
      forever begin
         @(posedge clk);
         lat++;
         @(negedge clk);
         if (rsp_valid) break;
      end
      d   = rsp_data;
      nfl = fl_count - base;
   endtask

   task automatic req_addr_set(input logic [23:0] a);
      req_waddr = a[23:2];
   endtask

   task automatic rd_chk(input string tag, input logic [23:0] a, input logic ins,
                         input int exp_nfl, input int exp_lat);
      logic [31:0] d;
      int nfl, lat;
      rd(a, ins, d, nfl, lat);
      chk({tag, " data"}, d, exp_word(a));
      chk({tag, " flash reads"}, 32'(nfl), 32'(exp_nfl));
      if (exp_lat >= 0) chk({tag, " latency"}, 32'(lat), 32'(exp_lat));
   endtask

   task automatic do_inv(output int n);
      @(negedge clk);
      inv_req = 1'b1;
      @(negedge clk);
      inv_req = 1'b0;
      n = 0;
      while (!ready && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      chk("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
      chk("R1 fl_rd after reset", 32'(fl_rd), 32'd0);
      chk("R1 req_ready after reset", 32'(req_ready), 32'd1);
      chk("R10 ready low while disabled", 32'(ready), 32'd0);
   endtask

   task automatic t_uncached();
      rd_chk("R6 master off first", 24'h000104, 1'b0, 1, 2);
      rd_chk("R6 master off repeat", 24'h000104, 1'b0, 1, 2);
   endtask

   task automatic t_miss_hit();
      cfg_en = 1'b1; cfg_ien = 1'b1; cfg_den = 1'b1;
      @(negedge clk);
      chk("R10 ready when enabled", 32'(ready), 32'd1);
      rd_chk("R4 miss word1", 24'h001234, 1'b0, 1, 2);
      rd_chk("R3 hit word2", 24'h001238, 1'b0, 0, 1);
      rd_chk("R2 hit word0", 24'h001230, 1'b1, 0, 1);
      rd_chk("R2 hit word3", 24'h00123C, 1'b0, 0, 1);
   endtask

   task automatic t_wait();
      for (int w = 1; w < 4; w++) begin
         bw = w;
         cfg_wait = 2'(w);
         rd_chk("R5 wait states", 24'h003000 + 24'(w*16) + 24'h4, 1'b0, 1, 2 + w);
      end
      bw = 0;
      cfg_wait = 2'd0;
   endtask

   task automatic t_class();
      cfg_den = 1'b0;
      rd_chk("R6 loads disabled first", 24'h004040, 1'b0, 1, -1);
      rd_chk("R6 loads disabled repeat", 24'h004040, 1'b0, 1, -1);
      rd_chk("R6 fetch still caches miss", 24'h004040, 1'b1, 1, -1);
      rd_chk("R6 fetch still caches hit", 24'h004044, 1'b1, 0, 1);
      cfg_den = 1'b1; cfg_ien = 1'b0;
      rd_chk("R6 fetches disabled bypass", 24'h001234, 1'b1, 1, -1);
      cfg_ien = 1'b1;
      rd_chk("R6 bypass left line resident", 24'h001234, 1'b1, 0, 1);
   endtask

   task automatic t_window();
      cfg_win_lo[19:0]  = 20'h00200;
      cfg_win_hi[19:0]  = 20'h00203;
      cfg_win_lo[39:20] = 20'h00500;
      cfg_win_hi[39:20] = 20'h00500;
      cfg_win_en = 2'b01;
      rd_chk("R7 upper bound first", 24'h00203C, 1'b0, 1, -1);
      rd_chk("R7 upper bound repeat", 24'h00203C, 1'b0, 1, -1);
      rd_chk("R7 lower bound", 24'h002000, 1'b0, 1, -1);
      rd_chk("R7 above window miss", 24'h002040, 1'b0, 1, -1);
      rd_chk("R7 above window hit", 24'h002040, 1'b0, 0, 1);
      cfg_win_en = 2'b10;
      rd_chk("R7 window1 first", 24'h005008, 1'b1, 1, -1);
      rd_chk("R7 window1 repeat", 24'h005008, 1'b1, 1, -1);
      rd_chk("R7 window0 off miss", 24'h00203C, 1'b0, 1, -1);
      rd_chk("R7 window0 off hit", 24'h00203C, 1'b0, 0, 1);
      cfg_win_en = 2'b00;
   endtask

   task automatic t_inv();
      int n;
      do_inv(n);
      chk("R10 sweep length", 32'(n), 32'd256);
      rd_chk("R10 line gone after sweep", 24'h001234, 1'b0, 1, -1);
   endtask

   task automatic t_lrr();
      int n;
      do_inv(n);
      cfg_lru = 1'b0;
      rd_chk("R8 fill A", 24'h001550, 1'b0, 1, -1);
      rd_chk("R8 fill B", 24'h002550, 1'b0, 1, -1);
      rd_chk("R8 hit A", 24'h001554, 1'b0, 0, 1);
      rd_chk("R8 fill C", 24'h003550, 1'b0, 1, -1);
      rd_chk("R8 B kept", 24'h002550, 1'b0, 0, 1);
      rd_chk("R8 A evicted", 24'h001550, 1'b0, 1, -1);
   endtask

   task automatic t_lru();
      int n;
      do_inv(n);
      cfg_lru = 1'b1;
      rd_chk("R9 fill A", 24'h001660, 1'b0, 1, -1);
      rd_chk("R9 fill B", 24'h002660, 1'b0, 1, -1);
      rd_chk("R9 hit A", 24'h001668, 1'b0, 0, 1);
      rd_chk("R9 fill C", 24'h003660, 1'b0, 1, -1);
      rd_chk("R9 A kept", 24'h001660, 1'b0, 0, 1);
      rd_chk("R9 B evicted", 24'h002660, 1'b0, 1, -1);
      cfg_lru = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_uncached();
      t_miss_hit();
      t_wait();
      t_class();
      t_window();
      t_inv();
      t_lrr();
      t_lru();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired, actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule